// File: doc/BRIEF.md
# Dual-Port Mailbox RAM with Cross-Port Interrupt Flags

This block is a 1024 x 8 memory with two independent access ports, called left and right, that share one clock. Each port has an active-low select, a read/write strobe (low means write), an active-low output enable, a 10-bit address, write data, and an active-low write-inhibit input. Both ports may read or write any word in the same cycle. Read data is registered. It comes with a valid flag one clock after the request and is forced to zero on cycles when no read took place.

The two highest words also serve as message boxes between the ports. Word 0x3FE belongs to the left port and word 0x3FF belongs to the right port. When one port writes the other port's box, that other port's active-low interrupt is raised. The owner clears its interrupt by accessing its own box. The message byte is stored in the array like any other data, so the receiver reads it during the same access that clears the interrupt.

Top module: `mbox_dpram`

## Requirements
- R1: A port writes word `addr` with its write data when its select and read/write strobe are both low and its write-inhibit is high. The word can then be read from either port. All 1024 words are reachable from both ports.
- R2: A port reads when its select is low, its read/write strobe is high and its output enable is low. On the next clock its data output carries the addressed word and its valid flag is high. On any other cycle the data output is zero and the valid flag is low.
- R3: The left interrupt output (active low) goes low on the clock after the right port performs a write to address 0x3FE.
- R4: The left interrupt returns high on the clock after the left port has its select and output enable low at address 0x3FE. The read/write strobe has no effect on this clear.
- R5: The right interrupt output (active low) goes low on the clock after the left port writes 0x3FF. It returns high on the clock after the right port has its select and output enable low at 0x3FF.
- R6: A write to a box address also stores the byte in the array, and that byte reads back from either port.
- R7: While a port's write-inhibit input is low, its write changes neither the array nor the opposite port's interrupt.
- R8: While synchronous active-low reset is held, both interrupt outputs are high, both valid flags are low and both data outputs are zero after each clock.
- R9: If a set and a clear of the same interrupt occur in one cycle, the interrupt ends up asserted (low).
- R10: If both ports write the same address in one cycle and neither is inhibited, the left port's byte is stored.
- R11: A read in the same cycle as a write to the same address by the other port returns the word's contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_cen | input | 1 | Left select, active low |
| l_rwn | input | 1 | Left read (1) / write (0) |
| l_oen | input | 1 | Left output enable, active low |
| l_addr | input | 10 | Left address |
| l_wdata | input | 8 | Left write data |
| l_wbusy_n | input | 1 | Left write inhibit, active low |
| l_rdata | output | 8 | Left registered read data |
| l_rvalid | output | 1 | Left read data valid |
| l_int_n | output | 1 | Left interrupt, active low |
| r_cen | input | 1 | Right select, active low |
| r_rwn | input | 1 | Right read (1) / write (0) |
| r_oen | input | 1 | Right output enable, active low |
| r_addr | input | 10 | Right address |
| r_wdata | input | 8 | Right write data |
| r_wbusy_n | input | 1 | Right write inhibit, active low |
| r_rdata | output | 8 | Right registered read data |
| r_rvalid | output | 1 | Right read data valid |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
A port can clear its own interrupt in the same cycle as the peer writes a new message to that box. A write collision can also coincide with a read of the written word by the other port. The bench provokes the first case by having the peer write 0x3FE or 0x3FF while the owner is accessing the same box. It provokes the second case by driving both ports onto one address with write/write and write/read mixes. The bench's reference model decides every case on its own terms: set wins over clear, left data wins a collision, and a read sees the old contents. Its predicted flags and read data are compared with the outputs after every clock, during directed sequences and during a long run of randomized traffic that is biased toward the box addresses.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   // Decoded per-port activity for one cycle
   typedef struct packed {
      logic rd;        // port performs a read
      logic wr;        // port performs an uninhibited write
      logic clr_own;   // port touches its own box (clears its flag)
      logic set_peer;  // port writes the peer's box (raises peer flag)
   } port_act_t;

   localparam int NPORT = 2;
   localparam int LEFT  = 0;
   localparam int RIGHT = 1;
endpackage

// File: rtl/mbox_port_ctl.sv
module mbox_port_ctl
   import mbox_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int OWN_BOX  = 1022,
   parameter int PEER_BOX = 1023
) (
   input  logic              cen,
   input  logic              rwn,
   input  logic              oen,
   input  logic              wbusy_n,
   input  logic [ADDR_W-1:0] addr,
   output port_act_t         act
);
   localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_BOX);
   localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_BOX);

   logic sel;
   assign sel = ~cen;

   always_comb begin
      act.rd       = sel & rwn & ~oen;
      act.wr       = sel & ~rwn & wbusy_n;
      act.clr_own  = sel & ~oen & (addr == OWN_A);
      act.set_peer = act.wr & (addr == PEER_A);
   end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic int_n
);
   always_ff @(posedge clk) begin
      if (!rst_n)   int_n <= 1'b1;
      else if (set) int_n <= 1'b0;   // a new message outranks a clear
      else if (clr) int_n <= 1'b1;
   end
endmodule

// File: rtl/mbox_array.sv
module mbox_array
   import mbox_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NPORT-1:0]             wr,
   input  logic [NPORT-1:0][ADDR_W-1:0] addr,
   input  logic [NPORT-1:0][DATA_W-1:0] wdata,
   input  logic [NPORT-1:0]             rd,
   output logic [NPORT-1:0][DATA_W-1:0] rdata,
   output logic [NPORT-1:0]             rvalid
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // Right first, then left: left wins an address collision
   always_ff @(posedge clk) begin
      if (wr[RIGHT]) mem[addr[RIGHT]] <= wdata[RIGHT];
      if (wr[LEFT])  mem[addr[LEFT]]  <= wdata[LEFT];
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_rd
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rvalid[p] <= 1'b0;
            rdata[p]  <= '0;
         end else begin
            rvalid[p] <= rd[p];
            rdata[p]  <= rd[p] ? mem[addr[p]] : '0;
         end
      end
   end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
   import mbox_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_cen,
   input  logic              l_rwn,
   input  logic              l_oen,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic              l_wbusy_n,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rvalid,
   output logic              l_int_n,
   input  logic              r_cen,
   input  logic              r_rwn,
   input  logic              r_oen,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic              r_wbusy_n,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rvalid,
   output logic              r_int_n
);
   localparam int DEPTH   = 1 << ADDR_W;
   localparam int BOX_LFT = DEPTH - 2;
   localparam int BOX_RGT = DEPTH - 1;

   if (ADDR_W < 2)  begin : g_bad_aw $error("ADDR_W must be at least 2"); end
   if (DATA_W < 1)  begin : g_bad_dw $error("DATA_W must be at least 1"); end

   logic [NPORT-1:0]             cen, rwn, oen, wbn;
   logic [NPORT-1:0][ADDR_W-1:0] addr;
   logic [NPORT-1:0][DATA_W-1:0] wdata, rdata;
   logic [NPORT-1:0]             wr, rd, rvalid, int_n;
   port_act_t                    act [NPORT];

   assign cen   = {r_cen, l_cen};
   assign rwn   = {r_rwn, l_rwn};
   assign oen   = {r_oen, l_oen};
   assign wbn   = {r_wbusy_n, l_wbusy_n};
   assign addr  = {r_addr, l_addr};
   assign wdata = {r_wdata, l_wdata};

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      localparam int OWN  = (p == LEFT) ? BOX_LFT : BOX_RGT;
      localparam int PEER = (p == LEFT) ? BOX_RGT : BOX_LFT;

      mbox_port_ctl #(.ADDR_W(ADDR_W), .OWN_BOX(OWN), .PEER_BOX(PEER)) u_ctl (
         .cen(cen[p]), .rwn(rwn[p]), .oen(oen[p]), .wbusy_n(wbn[p]),
         .addr(addr[p]), .act(act[p])
      );

      mbox_flag u_flag (
         .clk(clk), .rst_n(rst_n),
         .set(act[NPORT-1-p].set_peer), .clr(act[p].clr_own),
         .int_n(int_n[p])
      );

      assign wr[p] = act[p].wr;
      assign rd[p] = act[p].rd;
   end

   mbox_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
      .rd(rd), .rdata(rdata), .rvalid(rvalid)
   );

   assign l_rdata  = rdata[LEFT];
   assign r_rdata  = rdata[RIGHT];
   assign l_rvalid = rvalid[LEFT];
   assign r_rvalid = rvalid[RIGHT];
   assign l_int_n  = int_n[LEFT];
   assign r_int_n  = int_n[RIGHT];
endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_cen,
   input logic              l_rwn,
   input logic              l_oen,
   input logic [ADDR_W-1:0] l_addr,
   input logic              l_wbusy_n,
   input logic [DATA_W-1:0] l_rdata,
   input logic              l_rvalid,
   input logic              l_int_n,
   input logic              r_cen,
   input logic              r_rwn,
   input logic              r_oen,
   input logic [ADDR_W-1:0] r_addr,
   input logic              r_wbusy_n,
   input logic [DATA_W-1:0] r_rdata,
   input logic              r_rvalid,
   input logic              r_int_n
);
   localparam logic [ADDR_W-1:0] LBOX = ADDR_W'((1 << ADDR_W) - 2);
   localparam logic [ADDR_W-1:0] RBOX = ADDR_W'((1 << ADDR_W) - 1);

   logic set_l, set_r, clr_l, clr_r, rd_l, rd_r;
   assign set_l = !r_cen && !r_rwn && r_wbusy_n && (r_addr == LBOX);
   assign set_r = !l_cen && !l_rwn && l_wbusy_n && (l_addr == RBOX);
   assign clr_l = !l_cen && !l_oen && (l_addr == LBOX);
   assign clr_r = !r_cen && !r_oen && (r_addr == RBOX);
   assign rd_l  = !l_cen && l_rwn && !l_oen;
   assign rd_r  = !r_cen && r_rwn && !r_oen;

   // R3
   set_left_chk: assert property (@(posedge clk) disable iff (!rst_n) set_l |=> !l_int_n);
   // R5
   set_right_chk: assert property (@(posedge clk) disable iff (!rst_n) set_r |=> !r_int_n);
   // R4
   clr_left_chk: assert property (@(posedge clk) disable iff (!rst_n) (clr_l && !set_l) |=> l_int_n);
   // R5
   clr_right_chk: assert property (@(posedge clk) disable iff (!rst_n) (clr_r && !set_r) |=> r_int_n);
   // R7
   hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n) (l_int_n && !set_l) |=> l_int_n);
   // R7
   hold_right_chk: assert property (@(posedge clk) disable iff (!rst_n) (r_int_n && !set_r) |=> r_int_n);
   // R2
   lvalid_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_l |=> l_rvalid);
   // R2
   rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_r |=> r_rvalid);
   // R2
   lidle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !l_rvalid |-> (l_rdata == '0));
   // R2
   ridle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !r_rvalid |-> (r_rdata == '0));
   // R8
   reset_flags_chk: assert property (@(posedge clk) !rst_n |=> (l_int_n && r_int_n && !l_rvalid && !r_rvalid));
endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .l_cen(l_cen), .l_rwn(l_rwn), .l_oen(l_oen), .l_addr(l_addr), .l_wbusy_n(l_wbusy_n),
   .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_int_n(l_int_n),
   .r_cen(r_cen), .r_rwn(r_rwn), .r_oen(r_oen), .r_addr(r_addr), .r_wbusy_n(r_wbusy_n),
   .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_int_n(r_int_n)
);

// File: tb/sim_mbox_dpram.sv
module sim_mbox_dpram;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       l_cen, l_rwn, l_oen, l_wbusy_n, r_cen, r_rwn, r_oen, r_wbusy_n;
   logic [9:0] l_addr, r_addr;
   logic [7:0] l_wdata, r_wdata, l_rdata, r_rdata;
   logic       l_rvalid, r_rvalid, l_int_n, r_int_n;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 0;

   byte unsigned ref_mem [1024];
   bit   ref_lint = 1, ref_rint = 1;

   always #5 clk = ~clk;

   mbox_dpram u0 (.*);

   task automatic lset(input logic cen, rwn, oen, input int a, input int d, input logic bn);
      l_cen = cen; l_rwn = rwn; l_oen = oen; l_addr = 10'(a); l_wdata = 8'(d); l_wbusy_n = bn;
   endtask
   task automatic rset(input logic cen, rwn, oen, input int a, input int d, input logic bn);
      r_cen = cen; r_rwn = rwn; r_oen = oen; r_addr = 10'(a); r_wdata = 8'(d); r_wbusy_n = bn;
   endtask
   task automatic idle();
      lset(1, 1, 1, 0, 0, 1);
      rset(1, 1, 1, 0, 0, 1);
   endtask

   // One clock of the reference model, then compare every output
   task automatic step(input string tag);
      bit lrd, rrd, lwr, rwr, lset_f, rset_f, lclr, rclr, e_li, e_ri;
      byte unsigned e_ld, e_rd;
      lrd = rst_n && !l_cen && l_rwn && !l_oen;
      rrd = rst_n && !r_cen && r_rwn && !r_oen;
      e_ld = lrd ? ref_mem[l_addr] : 8'h00;
      e_rd = rrd ? ref_mem[r_addr] : 8'h00;
      lwr = !l_cen && !l_rwn && l_wbusy_n;
      rwr = !r_cen && !r_rwn && r_wbusy_n;
      lset_f = rwr && r_addr == 10'h3FE;
      rset_f = lwr && l_addr == 10'h3FF;
      lclr = !l_cen && !l_oen && l_addr == 10'h3FE;
      rclr = !r_cen && !r_oen && r_addr == 10'h3FF;
      if (!rst_n) begin e_li = 1; e_ri = 1; end
      else begin
         e_li = lset_f ? 0 : (lclr ? 1 : ref_lint);
         e_ri = rset_f ? 0 : (rclr ? 1 : ref_rint);
      end
      if (rwr) ref_mem[r_addr] = r_wdata;
      if (lwr) ref_mem[l_addr] = l_wdata;
      ref_lint = e_li; ref_rint = e_ri;
      @(posedge clk); #1;
      n_tests++;
      if (l_rdata !== e_ld || l_rvalid !== lrd || l_int_n !== e_li) begin
         n_fail++;
         $display("FAIL %s left: data=%h valid=%b int_n=%b expected data=%h valid=%b int_n=%b",
                  tag, l_rdata, l_rvalid, l_int_n, e_ld, lrd, e_li);
      end
      n_tests++;
      if (r_rdata !== e_rd || r_rvalid !== rrd || r_int_n !== e_ri) begin
         n_fail++;
         $display("FAIL %s right: data=%h valid=%b int_n=%b expected data=%h valid=%b int_n=%b",
                  tag, r_rdata, r_rvalid, r_int_n, e_rd, rrd, e_ri);
      end
   endtask

   initial begin
      rst_n = 0; idle();
      step("R8 reset"); step("R8 reset");
      rst_n = 1;
      // R1: fill the whole array, left low half, right high half
      for (int i = 0; i < 512; i++) begin
         lset(0, 0, 1, i, (i * 7 + 3) & 255, 1);
         rset(0, 0, 1, i + 512, (i * 13 + 91) & 255, 1);
         step("R1 fill");
      end
      // R1/R2: cross reads
      for (int i = 0; i < 8; i++) begin
         lset(0, 1, 0, 600 + i * 37, 0, 1);
         rset(0, 1, 0, i * 41, 0, 1);
         step("R1 R2 cross read");
      end
      // R2: select low but output enable high -> no read
      lset(0, 1, 1, 5, 0, 1); rset(1, 1, 0, 5, 0, 1);
      step("R2 no read");
      idle(); step("R2 idle");
      // R3/R6: right posts message to left box
      rset(0, 0, 1, 'h3FE, 'hA5, 1); step("R3 set left");
      idle(); step("R3 held");
      // R4/R6: left reads its box, clears flag
      lset(0, 1, 0, 'h3FE, 0, 1); step("R4 R6 clear by read");
      idle(); step("R4 R6 read data");
      // R4: clear with read/write low (also writes)
      rset(0, 0, 1, 'h3FE, 'h3C, 1); step("R3 set again");
      lset(0, 0, 0, 'h3FE, 'h11, 1); rset(1, 1, 1, 0, 0, 1); step("R4 clear rwn low");
      // R5: left posts to right box, right clears
      lset(0, 0, 1, 'h3FF, 'h5A, 1); step("R5 set right");
      idle(); step("R5 held");
      rset(0, 1, 0, 'h3FF, 0, 1); step("R5 clear right");
      lset(0, 1, 0, 'h3FF, 0, 1); rset(1, 1, 1, 0, 0, 1); step("R6 left reads right box");
      idle(); step("R6 data");
      // R7: inhibited writes
      rset(0, 0, 1, 'h3FE, 'hEE, 0); step("R7 inhibited set");
      lset(0, 0, 1, 'h3FF, 'hEE, 0); rset(1, 1, 1, 0, 0, 1); step("R7 inhibited set");
      lset(0, 1, 0, 'h3FF, 0, 1); rset(0, 1, 0, 'h3FE, 0, 1); step("R7 contents kept");
      idle(); step("R7 idle");
      // R9: set and clear collide
      lset(0, 1, 0, 'h3FE, 0, 1); rset(0, 0, 1, 'h3FE, 'h77, 1); step("R9 set beats clear L");
      lset(0, 0, 1, 'h3FF, 'h66, 1); rset(0, 1, 0, 'h3FF, 0, 1); step("R9 set beats clear R");
      idle(); step("R9 held");
      // R10: same-address write collision
      lset(0, 0, 1, 100, 'hC1, 1); rset(0, 0, 1, 100, 'h2D, 1); step("R10 collide");
      lset(1, 1, 1, 0, 0, 1); rset(0, 1, 0, 100, 0, 1); step("R10 read back");
      // R11: read during other port's write
      lset(0, 0, 1, 200, 'h99, 1); rset(0, 1, 0, 200, 0, 1); step("R11 old data");
      lset(1, 1, 1, 0, 0, 1); rset(0, 1, 0, 200, 0, 1); step("R11 new data");
      // Randomized traffic biased to the boxes (R1..R11)
      for (int i = 0; i < 3000; i++) begin
         int sel;
         int la, ra;
         sel = $urandom_range(0, 3);
         la = (sel == 0) ? 'h3FE : (sel == 1) ? 'h3FF : (sel == 2) ? 300 : $urandom_range(0, 1023);
         sel = $urandom_range(0, 3);
         ra = (sel == 0) ? 'h3FE : (sel == 1) ? 'h3FF : (sel == 2) ? 300 : $urandom_range(0, 1023);
         lset(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              la, $urandom_range(0, 255), 1'($urandom_range(0, 3) != 0));
         rset(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              ra, $urandom_range(0, 255), 1'($urandom_range(0, 3) != 0));
         step("R9 R10 R11 random");
      end
      idle(); step("final");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule